// File: doc/BRIEF.md
# Two-Way Cache Tag and State Directory

This block is the bookkeeping half of a two-way set-associative cache with 32-byte lines. For every set it keeps, per way, a stored address tag, a valid flag and a dirty flag, plus one replacement bit shared by the two ways of the set. A 29-bit physical address is presented on `req_addr`. In the same cycle the block answers whether that address hits, in which way, and which way would be replaced on a miss. For that victim way it also gives the valid flag, the dirty flag and the stored tag, so a write-back can be requested first.

Commands are committed on the next rising clock edge: read or write accesses, a fill of the victim way, or an invalidate of the hitting way. A mode input selects copy-back or write-through, and only copy-back writes mark a line dirty. Two synchronous active-low resets are provided. Power-on reset clears all valid, dirty and replacement state. Manual reset leaves every stored bit untouched and only blocks updates while it is held. Tags are never reset. The data array, the bus transfers and any software access path lie outside this block.

Top module: `way2_tag_dir`

## Requirements
- R1: With default parameters the address splits into byte offset `[4:0]`, set index `[9:5]` and tag `[28:10]`. A way hits only when its valid flag is set and its stored tag equals the address tag. The offset has no effect on the result.
- R2: While `por_n` is low at a clock edge, all valid, dirty and replacement bits are cleared. After that, every lookup misses and reports victim way 0 with `vict_valid`=0 and `vict_dirty`=0.
- R3: While `mrst_n` is low (and `por_n` high), no command changes any state. Valid, dirty, tag and replacement state are all kept, so earlier entries still hit afterwards.
- R4: A write that hits while `copy_back`=1 sets the dirty flag of the hit way.
- R5: A write that hits while `copy_back`=0 never sets a dirty flag.
- R6: A read or write hit sets the set's replacement bit to the other way (bit value 0 names way 0, value 1 names way 1).
- R7: The victim is the first invalid way (way 0 before way 1). If both ways are valid, the victim is the way named by the replacement bit. `vict_valid`, `vict_dirty` and `vict_tag` describe that way.
- R8: A fill on a miss writes the address tag into the victim way, sets its valid flag, clears its dirty flag and points the replacement bit at the other way. A fill request while the address hits is ignored.
- R9: An invalidate that hits clears the valid and dirty flags of the hit way. An invalidate that misses has no effect.
- R10: When invalidate and write are requested in the same cycle on a hit, the invalidate wins and no dirty flag is set.
- R11: A read or write that misses changes neither dirty flags nor the replacement bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all updates on the rising edge |
| por_n | input | 1 | Power-on reset, synchronous, active low; clears valid, dirty, replacement |
| mrst_n | input | 1 | Manual reset, synchronous, active low; freezes all state |
| copy_back | input | 1 | 1 = copy-back mode, 0 = write-through mode |
| req_addr | input | 29 | Physical address being looked up |
| req_rd | input | 1 | Read access request |
| req_wr | input | 1 | Write access request |
| fill_en | input | 1 | Fill the victim way with the address tag (only on a miss) |
| inv_en | input | 1 | Invalidate the hitting way |
| hit | output | 1 | Address hits in one way |
| hit_way | output | 1 | Way that hits |
| vict_way | output | 1 | Way to be replaced on a miss |
| vict_valid | output | 1 | Valid flag of the victim way |
| vict_dirty | output | 1 | Dirty flag of the victim way |
| vict_tag | output | 19 | Stored tag of the victim way |

## Verification
On every cycle, the assertions check several properties. At most one way matches. Write-through cycles never raise a dirty flag. A held manual reset freezes valid, dirty and replacement state. The cycle after a power-on reset leaves all flags clear. A fill makes the chosen way valid and clean, and an access hit leaves the replacement bit pointing away from the hit way. The directed scenarios are needed to show other behaviour: the victim order across a full sequence of fills and hits, tag retention through manual reset, that offset bits and fill-on-hit requests have no effect, and that invalidate wins over a same-cycle write.

// File: rtl/way2_tag_pkg.sv
// Package: shared widths and the way type for the two-way tag directory.
// Assumes a 29-bit physical address and 32-byte lines unless overridden at the top.
package way2_tag_pkg;
    localparam int ADDR_W_DEF = 29;
    localparam int LINE_BYTES_DEF = 32;
    localparam int SETS_DEF = 32;
    localparam int WAYS = 2;

    typedef logic way_t;
endpackage

// File: rtl/w2_way_bank.sv
// Module: storage for one way - tag array, valid vector and dirty vector.
// Assumes at most one of fill_we / inv_we / set_dirty is high per cycle and that
// the caller has already gated all commands with both resets.
module w2_way_bank #(
    parameter int SETS  = 32,
    parameter int TAG_W = 19,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] new_tag,
    input  logic             fill_we,
    input  logic             inv_we,
    input  logic             set_dirty,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_vld,
    output logic             rd_drt,
    output logic [SETS-1:0]  vld_vec,
    output logic [SETS-1:0]  drt_vec
);
    logic [TAG_W-1:0] tag_mem [SETS];

    // Tag storage: written on fill only, never reset.
    always_ff @(posedge clk) begin
        if (fill_we) begin
            tag_mem[idx] <= new_tag;
        end
    end

    // Valid flags: cleared by power-on reset, set on fill, cleared on invalidate.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            vld_vec <= '0;
        end else if (fill_we) begin
            vld_vec[idx] <= 1'b1;
        end else if (inv_we) begin
            vld_vec[idx] <= 1'b0;
        end
    end

    // Dirty flags: cleared by power-on reset, fill or invalidate; set by a copy-back write.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            drt_vec <= '0;
        end else if (fill_we || inv_we) begin
            drt_vec[idx] <= 1'b0;
        end else if (set_dirty) begin
            drt_vec[idx] <= 1'b1;
        end
    end

    // Read port for the current set.
    always_comb begin
        rd_tag = tag_mem[idx];
        rd_vld = vld_vec[idx];
        rd_drt = drt_vec[idx];
    end
endmodule

// File: rtl/w2_lru_bank.sv
// Module: one replacement bit per set; the value names the way to fill next.
// Assumes the update strobe is already gated by both resets.
module w2_lru_bank #(
    parameter int SETS = 32,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             upd_en,
    input  logic             upd_val,
    output logic             rd_bit,
    output logic [SETS-1:0]  lru_vec
);
    // Replacement bits: cleared by power-on reset, written on a hit or fill.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            lru_vec <= '0;
        end else if (upd_en) begin
            lru_vec[idx] <= upd_val;
        end
    end

    // Read port for the current set.
    assign rd_bit = lru_vec[idx];
endmodule

// File: rtl/w2_victim_sel.sv
// Module: picks the way to replace - first invalid way, else the replacement bit.
// Purely combinational; assumes exactly two ways.
module w2_victim_sel (
    input  logic [1:0] vld,
    input  logic       lru_bit,
    output logic       vict
);
    // Invalid way 0 wins, then invalid way 1, then the replacement bit.
    always_comb begin
        if (!vld[0]) begin
            vict = 1'b0;
        end else if (!vld[1]) begin
            vict = 1'b1;
        end else begin
            vict = lru_bit;
        end
    end
endmodule

// File: rtl/way2_tag_dir.sv
// Module: two-way set-associative tag and state directory.
// Lookups answer combinationally in the request cycle; fills, invalidates and
// access updates commit at the next rising edge. Power-on reset clears flags,
// manual reset freezes all state. Assumes at most one fill or invalidate per cycle.
module way2_tag_dir
    import way2_tag_pkg::*;
#(
    parameter int ADDR_W     = ADDR_W_DEF,
    parameter int LINE_BYTES = LINE_BYTES_DEF,
    parameter int SETS       = SETS_DEF,
    localparam int OFF_W = $clog2(LINE_BYTES),
    localparam int IDX_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              mrst_n,
    input  logic              copy_back,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic              fill_en,
    input  logic              inv_en,
    output logic              hit,
    output logic              hit_way,
    output logic              vict_way,
    output logic              vict_valid,
    output logic              vict_dirty,
    output logic [TAG_W-1:0]  vict_tag
);
    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] atag;
    logic [TAG_W-1:0] rd_tag [WAYS];
    logic [WAYS-1:0]  rd_vld;
    logic [WAYS-1:0]  rd_drt;
    logic [SETS-1:0]  vld_vec [WAYS];
    logic [SETS-1:0]  drt_vec [WAYS];
    logic [WAYS-1:0]  match;
    logic [WAYS-1:0]  fill_we;
    logic [WAYS-1:0]  inv_we;
    logic [WAYS-1:0]  dirty_we;
    logic             live, fill_go, inv_go, acc_go;
    logic             lru_bit, lru_upd, lru_val;
    logic [SETS-1:0]  lru_vec;

    // Address split into set index and tag.
    assign idx  = req_addr[OFF_W +: IDX_W];
    assign atag = req_addr[ADDR_W-1 -: TAG_W];

    // Command qualification: both resets released, fill only on miss, invalidate only on hit.
    always_comb begin
        live    = por_n && mrst_n;
        fill_go = live && fill_en && !hit;
        inv_go  = live && inv_en && hit;
        acc_go  = live && (req_rd || req_wr) && hit && !inv_go;
    end

    genvar w;
    generate
        for (w = 0; w < WAYS; w++) begin : g_way
            // Per-way strobes and hit compare.
            always_comb begin
                match[w]    = rd_vld[w] && (rd_tag[w] == atag);
                fill_we[w]  = fill_go && (vict_way == way_t'(w));
                inv_we[w]   = inv_go && (hit_way == way_t'(w));
                dirty_we[w] = acc_go && req_wr && copy_back && (hit_way == way_t'(w));
            end

            w2_way_bank #(.SETS(SETS), .TAG_W(TAG_W)) u_bank (
                .clk       (clk),
                .por_n     (por_n),
                .idx       (idx),
                .new_tag   (atag),
                .fill_we   (fill_we[w]),
                .inv_we    (inv_we[w]),
                .set_dirty (dirty_we[w]),
                .rd_tag    (rd_tag[w]),
                .rd_vld    (rd_vld[w]),
                .rd_drt    (rd_drt[w]),
                .vld_vec   (vld_vec[w]),
                .drt_vec   (drt_vec[w])
            );
        end
    endgenerate

    // Hit result.
    assign hit     = |match;
    assign hit_way = match[1];

    // Replacement update: point away from the way just used or filled.
    always_comb begin
        lru_upd = fill_go || acc_go;
        lru_val = fill_go ? ~vict_way : ~hit_way;
    end

    w2_lru_bank #(.SETS(SETS)) u_lru (
        .clk     (clk),
        .por_n   (por_n),
        .idx     (idx),
        .upd_en  (lru_upd),
        .upd_val (lru_val),
        .rd_bit  (lru_bit),
        .lru_vec (lru_vec)
    );

    w2_victim_sel u_vsel (
        .vld     (rd_vld),
        .lru_bit (lru_bit),
        .vict    (vict_way)
    );

    // Victim report.
    always_comb begin
        vict_valid = rd_vld[vict_way];
        vict_dirty = rd_drt[vict_way];
        vict_tag   = rd_tag[vict_way];
    end

    // R1: at most one way may match an address.
    a_r1_single_match: assert property (@(posedge clk) disable iff (!por_n)
        $countones(match) <= 1);

    // R2: the edge after power-on reset leaves every flag clear.
    a_r2_por_clears: assert property (@(posedge clk) disable iff (!por_n)
        $rose(por_n) |-> (vld_vec[0] == '0 && vld_vec[1] == '0 &&
                          drt_vec[0] == '0 && drt_vec[1] == '0 && lru_vec == '0));

    // R3: a held manual reset freezes valid, dirty and replacement state.
    a_r3_mrst_freeze: assert property (@(posedge clk) disable iff (!por_n)
        !mrst_n |=> (vld_vec[0] == $past(vld_vec[0]) && vld_vec[1] == $past(vld_vec[1]) &&
                     drt_vec[0] == $past(drt_vec[0]) && drt_vec[1] == $past(drt_vec[1]) &&
                     lru_vec == $past(lru_vec)));

    // R5: in write-through mode no dirty flag is newly raised.
    a_r5_wt_clean: assert property (@(posedge clk) disable iff (!por_n)
        !copy_back |=> ((drt_vec[0] & ~$past(drt_vec[0])) == '0 &&
                        (drt_vec[1] & ~$past(drt_vec[1])) == '0));

    // R6: after an access hit the replacement bit names the other way.
    a_r6_lru_flip: assert property (@(posedge clk) disable iff (!por_n)
        (acc_go && mrst_n) |=> lru_vec[$past(idx)] == ~$past(hit_way));

    // R8: a fill leaves the chosen way valid and clean.
    a_r8_fill_state: assert property (@(posedge clk) disable iff (!por_n)
        fill_go |=> (vld_vec[$past(vict_way)][$past(idx)] &&
                     !drt_vec[$past(vict_way)][$past(idx)]));
endmodule

// File: tb/sim_way2_tag_dir.sv
// Directed bench for way2_tag_dir: one task per scenario, each checks its own results.
module sim_way2_tag_dir;
    logic        clk = 1'b0;
    logic        por_n, mrst_n, copy_back;
    logic [28:0] req_addr;
    logic        req_rd, req_wr, fill_en, inv_en;
    logic        hit, hit_way, vict_way, vict_valid, vict_dirty;
    logic [18:0] vict_tag;
    int          total = 0;
    int          bad = 0;

    always #2 clk = ~clk;

    way2_tag_dir u0 (
        .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .copy_back(copy_back),
        .req_addr(req_addr), .req_rd(req_rd), .req_wr(req_wr),
        .fill_en(fill_en), .inv_en(inv_en), .hit(hit), .hit_way(hit_way),
        .vict_way(vict_way), .vict_valid(vict_valid), .vict_dirty(vict_dirty),
        .vict_tag(vict_tag)
    );

    localparam logic [18:0] TA = 19'h12345, TB = 19'h00abc, TC = 19'h7fff0;
    localparam logic [18:0] TD = 19'h3c3c3, TE = 19'h05a5a, TF = 19'h11111;
    localparam logic [18:0] TG = 19'h22222, TH = 19'h33333;

    function automatic logic [28:0] mk(input logic [18:0] t, input logic [4:0] s,
                                       input logic [4:0] o);
        return {t, s, o};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present an address with no command and let outputs settle.
    task automatic look(input logic [28:0] a);
        @(negedge clk);
        req_addr = a; req_rd = 0; req_wr = 0; fill_en = 0; inv_en = 0;
        #1;
    endtask

    // Issue one command cycle; it commits on the following rising edge.
    task automatic op(input logic [28:0] a, input logic rd, input logic wr,
                      input logic fl, input logic iv);
        @(negedge clk);
        req_addr = a; req_rd = rd; req_wr = wr; fill_en = fl; inv_en = iv;
        @(posedge clk);
        #1;
        req_rd = 0; req_wr = 0; fill_en = 0; inv_en = 0;
    endtask

    task automatic do_por();
        @(negedge clk); por_n = 0;
        @(negedge clk);
        @(negedge clk); por_n = 1;
    endtask

    task automatic t_reset();
        do_por();
        look(mk(TA, 5'd3, 5'd0));
        chk("R2 hit after por", hit, 0);
        chk("R2 victim way after por", vict_way, 0);
        chk("R2 victim valid after por", vict_valid, 0);
        chk("R2 victim dirty after por", vict_dirty, 0);
    endtask

    task automatic t_fill();
        op(mk(TA, 5'd3, 5'd0), 0, 0, 1, 0);
        look(mk(TA, 5'd3, 5'd17));
        chk("R1 hit with other offset", hit, 1);
        chk("R8 fill landed in way0", hit_way, 0);
        look(mk(TB, 5'd3, 5'd0));
        chk("R7 invalid way1 chosen", vict_way, 1);
        chk("R7 victim invalid", vict_valid, 0);
        op(mk(TB, 5'd3, 5'd0), 0, 0, 1, 0);
        look(mk(TB, 5'd3, 5'd31));
        chk("R8 second fill in way1", {hit, hit_way}, 2'b11);
    endtask

    task automatic t_lru();
        op(mk(TA, 5'd3, 5'd0), 1, 0, 0, 0);
        look(mk(TC, 5'd3, 5'd0));
        chk("R6 read way0 -> victim way1", vict_way, 1);
        chk("R7 victim tag B", vict_tag, TB);
        chk("R7 victim valid", vict_valid, 1);
        op(mk(TB, 5'd3, 5'd0), 1, 0, 0, 0);
        look(mk(TC, 5'd3, 5'd0));
        chk("R6 read way1 -> victim way0", vict_way, 0);
        chk("R7 victim tag A", vict_tag, TA);
    endtask

    task automatic t_copyback();
        copy_back = 1;
        op(mk(TA, 5'd3, 5'd4), 0, 1, 0, 0);
        op(mk(TB, 5'd3, 5'd0), 1, 0, 0, 0);
        look(mk(TC, 5'd3, 5'd0));
        chk("R4 copy-back write marks dirty", {vict_way, vict_dirty}, 2'b01);
    endtask

    task automatic t_writethrough();
        op(mk(TD, 5'd7, 5'd0), 0, 0, 1, 0);
        op(mk(TE, 5'd7, 5'd0), 0, 0, 1, 0);
        copy_back = 0;
        op(mk(TD, 5'd7, 5'd0), 0, 1, 0, 0);
        op(mk(TE, 5'd7, 5'd0), 1, 0, 0, 0);
        look(mk(TF, 5'd7, 5'd0));
        chk("R5 write-through victim way0", vict_way, 0);
        chk("R5 write-through leaves clean", vict_dirty, 0);
        chk("R7 victim tag D", vict_tag, TD);
    endtask

    task automatic t_writemiss();
        copy_back = 1;
        op(mk(TF, 5'd7, 5'd0), 0, 1, 0, 0);
        look(mk(TF, 5'd7, 5'd0));
        chk("R11 write miss no hit", hit, 0);
        chk("R11 write miss keeps lru", vict_way, 0);
        chk("R11 write miss keeps clean", vict_dirty, 0);
    endtask

    task automatic t_tagbits();
        look(mk(TD ^ 19'h40000, 5'd7, 5'd0));
        chk("R1 top tag bit differs -> miss", hit, 0);
        look(mk(TD, 5'd6, 5'd0));
        chk("R1 other index -> miss", hit, 0);
    endtask

    task automatic t_inval();
        op(mk(TA, 5'd3, 5'd0), 0, 0, 0, 1);
        look(mk(TA, 5'd3, 5'd0));
        chk("R9 invalidated line misses", hit, 0);
        chk("R9 invalid way is victim", {vict_way, vict_valid, vict_dirty}, 3'b000);
        op(mk(TG, 5'd7, 5'd0), 0, 0, 0, 1);
        look(mk(TD, 5'd7, 5'd0));
        chk("R9 missing invalidate keeps D", {hit, hit_way}, 2'b10);
        look(mk(TE, 5'd7, 5'd0));
        chk("R9 missing invalidate keeps E", {hit, hit_way}, 2'b11);
    endtask

    task automatic t_fillhit();
        op(mk(TD, 5'd7, 5'd0), 1, 0, 0, 0);
        op(mk(TD, 5'd7, 5'd0), 0, 0, 1, 0);
        look(mk(TE, 5'd7, 5'd0));
        chk("R8 fill on hit ignored", {hit, hit_way}, 2'b11);
        op(mk(TE, 5'd7, 5'd0), 1, 0, 0, 0);
    endtask

    task automatic t_prio();
        copy_back = 1;
        op(mk(TD, 5'd7, 5'd0), 0, 1, 0, 1);
        look(mk(TD, 5'd7, 5'd0));
        chk("R10 invalidate wins over write", hit, 0);
        chk("R10 no dirty left", {vict_way, vict_valid, vict_dirty}, 3'b000);
    endtask

    task automatic t_mrst();
        op(mk(TD, 5'd7, 5'd0), 0, 0, 1, 0);
        @(negedge clk); mrst_n = 0;
        op(mk(TH, 5'd9, 5'd0), 0, 0, 1, 0);
        op(mk(TD, 5'd7, 5'd0), 0, 1, 0, 0);
        op(mk(TE, 5'd7, 5'd0), 0, 0, 0, 1);
        @(negedge clk); mrst_n = 1;
        look(mk(TH, 5'd9, 5'd0));
        chk("R3 fill blocked in manual reset", {hit, vict_valid}, 2'b00);
        look(mk(TE, 5'd7, 5'd0));
        chk("R3 entry kept through manual reset", {hit, hit_way}, 2'b11);
        op(mk(TE, 5'd7, 5'd0), 1, 0, 0, 0);
        look(mk(TF, 5'd7, 5'd0));
        chk("R3 write blocked in manual reset", {vict_way, vict_dirty}, 2'b00);
        chk("R3 tag kept through manual reset", vict_tag, TD);
    endtask

    task automatic t_por_again();
        do_por();
        look(mk(TD, 5'd7, 5'd0));
        chk("R2 por invalidates D", hit, 0);
        look(mk(TE, 5'd7, 5'd0));
        chk("R2 por invalidates E", {hit, vict_valid}, 2'b00);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        por_n = 0; mrst_n = 1; copy_back = 0; req_addr = '0;
        req_rd = 0; req_wr = 0; fill_en = 0; inv_en = 0;
        t_reset();
        t_fill();
        t_lru();
        t_copyback();
        t_writethrough();
        t_writemiss();
        t_tagbits();
        t_inval();
        t_fillhit();
        t_prio();
        t_mrst();
        t_por_again();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule